// File: doc/BRIEF.md
# Keyed-Tone Character Receiver

This block turns a single on/off keyed line into ASCII characters. The line is idle low and goes high while the key is down. Each key-down pulse is timed and classed as a short element (dot) or a long element (dash). Each key-up interval is timed as well: a short one separates elements inside a character, and a long one closes the character. There are no start or stop bits, and a character may hold anywhere from one to five elements.

All timing runs on a unit tick taken from the system clock through a fixed prescaler. One nominal dot length is a set number of those ticks. When a character closes, its element sequence is looked up in a table of letters and digits. The resulting ASCII code is placed in a one-entry receive buffer and a receive-done flag is raised. Sequences that cannot be decoded give a fixed error code and raise an error flag. A read strobe empties the buffer. A character that arrives while the buffer is still full sets an overrun flag.

Top module: `morse_rx_decoder`

## Requirements
- R1: After reset, rx_done, rx_err and rx_ovr are 0 and rx_data is 8'h00. key_in passes through two synchronising flip-flops before it is timed.
- R2: A key-down pulse of at least half a unit and less than two units is taken as a dot.
- R3: A key-down pulse of two units or more is taken as a dash.
- R4: A key-down pulse shorter than half a unit adds no element, whether it falls in idle time or inside a character.
- R5: A key-up interval shorter than two units keeps the next element in the same character. An interval of two units or more ends the character.
- R6: Complete sequences decode to uppercase ASCII for the letters A to Z (8'h41 to 8'h5A) and the digits 0 to 9 (8'h30 to 8'h39), following the international dot/dash code.
- R7: A character of six or more elements gives rx_data = 8'h3F with rx_err = 1.
- R8: A sequence of five or fewer elements that matches no table entry gives rx_data = 8'h3F with rx_err = 1. rx_err is 0 for a character that decodes.
- R9: rx_done goes to 1 in the cycle after a character is decoded and stays there until an rx_rd pulse clears it.
- R10: If a character completes while rx_done is 1 and rx_rd is not asserted, rx_ovr goes to 1 and the buffer takes the newer character. rx_rd clears rx_ovr. rx_ovr is never 1 while rx_done is 0.
- R11: rx_data and rx_err keep their values until the next character completes, including after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_in | input | 1 | Asynchronous keyed line, 1 = key down |
| rx_rd | input | 1 | One-cycle read strobe for the receive buffer |
| rx_data | output | 8 | ASCII code of the last received character |
| rx_done | output | 1 | Receive-done flag (buffer full) |
| rx_err | output | 1 | Last character could not be decoded |
| rx_ovr | output | 1 | A character overwrote an unread one |

## Verification
The assertions check the buffer-side rules on every cycle: the done flag follows each decoded character, a read clears it, overrun is set by an unread completion and never appears without done, the error flag always comes with the fixed error code, and the buffer only changes on a new character. Pulse and gap classification cannot be seen at the flags. Only the bench's stimuli show it: nominal and near-threshold pulse lengths, glitches in idle time and inside a character, short and long gaps, letters, digits, over-long frames and unknown patterns, each compared with the character that should come out.

// File: rtl/mrx_pkg.sv
// Shared constants, types and the element-sequence lookup for the keyed
// receiver. Patterns are right-aligned: the first element received is the
// most significant of the 'len' valid bits, and 1 means a dash.
package mrx_pkg;

    localparam int          MRX_MAX_ELEMS = 5;
    localparam int          MRX_LEN_W     = 3;
    localparam logic [7:0]  MRX_ERR_CODE  = 8'h3F;

    typedef struct packed {
        logic       hit;
        logic [7:0] code;
    } mrx_lookup_t;

    // Reverse table: element count plus pattern to ASCII.
    function automatic mrx_lookup_t mrx_lookup(input logic [MRX_LEN_W-1:0] len,
                                               input logic [MRX_MAX_ELEMS-1:0] pat);
        mrx_lookup_t r;
        r.hit  = 1'b1;
        r.code = MRX_ERR_CODE;
        case ({len, pat})
            {3'd1, 5'b00000}: r.code = 8'h45; // E
            {3'd1, 5'b00001}: r.code = 8'h54; // T
            {3'd2, 5'b00000}: r.code = 8'h49; // I
            {3'd2, 5'b00001}: r.code = 8'h41; // A
            {3'd2, 5'b00010}: r.code = 8'h4E; // N
            {3'd2, 5'b00011}: r.code = 8'h4D; // M
            {3'd3, 5'b00000}: r.code = 8'h53; // S
            {3'd3, 5'b00001}: r.code = 8'h55; // U
            {3'd3, 5'b00010}: r.code = 8'h52; // R
            {3'd3, 5'b00011}: r.code = 8'h57; // W
            {3'd3, 5'b00100}: r.code = 8'h44; // D
            {3'd3, 5'b00101}: r.code = 8'h4B; // K
            {3'd3, 5'b00110}: r.code = 8'h47; // G
            {3'd3, 5'b00111}: r.code = 8'h4F; // O
            {3'd4, 5'b00000}: r.code = 8'h48; // H
            {3'd4, 5'b00001}: r.code = 8'h56; // V
            {3'd4, 5'b00010}: r.code = 8'h46; // F
            {3'd4, 5'b00100}: r.code = 8'h4C; // L
            {3'd4, 5'b00110}: r.code = 8'h50; // P
            {3'd4, 5'b00111}: r.code = 8'h4A; // J
            {3'd4, 5'b01000}: r.code = 8'h42; // B
            {3'd4, 5'b01001}: r.code = 8'h58; // X
            {3'd4, 5'b01010}: r.code = 8'h43; // C
            {3'd4, 5'b01011}: r.code = 8'h59; // Y
            {3'd4, 5'b01100}: r.code = 8'h5A; // Z
            {3'd4, 5'b01101}: r.code = 8'h51; // Q
            {3'd5, 5'b11111}: r.code = 8'h30; // 0
            {3'd5, 5'b01111}: r.code = 8'h31; // 1
            {3'd5, 5'b00111}: r.code = 8'h32; // 2
            {3'd5, 5'b00011}: r.code = 8'h33; // 3
            {3'd5, 5'b00001}: r.code = 8'h34; // 4
            {3'd5, 5'b00000}: r.code = 8'h35; // 5
            {3'd5, 5'b10000}: r.code = 8'h36; // 6
            {3'd5, 5'b11000}: r.code = 8'h37; // 7
            {3'd5, 5'b11100}: r.code = 8'h38; // 8
            {3'd5, 5'b11110}: r.code = 8'h39; // 9
            default:          r.hit  = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mrx_sync.sv
// Multi-stage synchroniser for the asynchronous key line.
// Assumes STAGES >= 2 and that the line is idle low out of reset.
module mrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] sr;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d_async};
    end

    assign q_sync = sr[STAGES-1];

endmodule

// File: rtl/mrx_tick.sv
// Free-running prescaler that gives a one-cycle unit tick every DIV clocks.
// Assumes DIV >= 2.
module mrx_tick #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt;

    // Count clocks and wrap at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (cnt == CW'(DIV - 1))   cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CW'(DIV - 1));

endmodule

// File: rtl/mrx_timer.sv
// Run-length timer for the synchronised key line. A single saturating
// counter measures the current level in ticks and is cleared on each level
// change. It classifies a finished key-down pulse as dot, dash or glitch,
// and strobes once when a key-up interval reaches the character-end length.
// Assumes 1 <= HALF_TICKS <= DASH_TICKS and GAP_TICKS >= 1.
module mrx_timer #(
    parameter int HALF_TICKS = 2,
    parameter int DASH_TICKS = 8,
    parameter int GAP_TICKS  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic key_s,
    output logic elem_stb,
    output logic elem_dash,
    output logic gap_stb
);

    localparam int MAX_T = (DASH_TICKS > GAP_TICKS) ? DASH_TICKS : GAP_TICKS;
    localparam int CW    = $clog2(MAX_T + 1);

    logic          key_d;
    logic [CW-1:0] run_cnt;
    logic          key_fall;
    logic          key_low;

    // Track the previous level and count ticks at a stable level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_d   <= 1'b0;
            run_cnt <= '0;
        end else begin
            key_d <= key_s;
            if (key_s != key_d)
                run_cnt <= '0;
            else if (tick && run_cnt != CW'(MAX_T))
                run_cnt <= run_cnt + 1'b1;
        end
    end

    // Classify at the end of a pulse, and flag the gap threshold once.
    always_comb begin
        key_fall  = key_d & ~key_s;
        key_low   = ~key_d & ~key_s;
        elem_stb  = key_fall && (run_cnt >= CW'(HALF_TICKS));
        elem_dash = (run_cnt >= CW'(DASH_TICKS));
        gap_stb   = key_low && tick && (run_cnt == CW'(GAP_TICKS - 1));
    end

endmodule

// File: rtl/mrx_frame.sv
// Collects elements into a variable-length frame and decodes it when the
// character-end strobe arrives. Frames longer than the table allows are
// tracked by a saturating length and reported as errors.
// Assumes elem_stb and gap_stb never coincide.
module mrx_frame
    import mrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       elem_stb,
    input  logic       elem_dash,
    input  logic       gap_stb,
    output logic       char_stb,
    output logic [7:0] char_code,
    output logic       char_err
);

    localparam logic [MRX_LEN_W-1:0] LEN_MAX = MRX_LEN_W'(MRX_MAX_ELEMS);
    localparam logic [MRX_LEN_W-1:0] LEN_OVF = MRX_LEN_W'(MRX_MAX_ELEMS + 1);

    logic [MRX_LEN_W-1:0]     len;
    logic [MRX_MAX_ELEMS-1:0] pat;
    mrx_lookup_t              lk;
    logic                     bad;

    // Look up the frame collected so far.
    always_comb begin
        lk  = mrx_lookup(len, pat);
        bad = (len > LEN_MAX) || !lk.hit;
    end

    // Append elements, then close and decode the frame on a long gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len       <= '0;
            pat       <= '0;
            char_stb  <= 1'b0;
            char_code <= 8'h00;
            char_err  <= 1'b0;
        end else begin
            char_stb <= 1'b0;
            if (elem_stb) begin
                if (len < LEN_OVF) len <= len + 1'b1;
                if (len < LEN_MAX) pat <= {pat[MRX_MAX_ELEMS-2:0], elem_dash};
            end else if (gap_stb && len != '0) begin
                char_stb  <= 1'b1;
                char_code <= bad ? MRX_ERR_CODE : lk.code;
                char_err  <= bad;
                len       <= '0;
                pat       <= '0;
            end
        end
    end

endmodule

// File: rtl/morse_rx_decoder.sv
// Keyed-line character receiver: synchroniser, unit-tick prescaler, pulse
// and gap timer, frame decoder and a one-entry receive buffer with done,
// error and overrun flags. The unit is CLK_DIV * UNIT_TICKS clocks; the
// dash and character-end thresholds are two units and the glitch limit is
// half a unit. Assumes UNIT_TICKS >= 2 and CLK_DIV >= 2.
module morse_rx_decoder #(
    parameter int CLK_DIV     = 16,
    parameter int UNIT_TICKS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_in,
    input  logic       rx_rd,
    output logic [7:0] rx_data,
    output logic       rx_done,
    output logic       rx_err,
    output logic       rx_ovr
);

    localparam int HALF_TICKS = UNIT_TICKS / 2;
    localparam int DASH_TICKS = 2 * UNIT_TICKS;
    localparam int GAP_TICKS  = 2 * UNIT_TICKS;

    logic       key_s;
    logic       tick;
    logic       elem_stb;
    logic       elem_dash;
    logic       gap_stb;
    logic       char_stb;
    logic [7:0] char_code;
    logic       char_err;

    mrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (key_in),
        .q_sync  (key_s)
    );

    mrx_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    mrx_timer #(
        .HALF_TICKS (HALF_TICKS),
        .DASH_TICKS (DASH_TICKS),
        .GAP_TICKS  (GAP_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .key_s     (key_s),
        .elem_stb  (elem_stb),
        .elem_dash (elem_dash),
        .gap_stb   (gap_stb)
    );

    mrx_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .elem_stb  (elem_stb),
        .elem_dash (elem_dash),
        .gap_stb   (gap_stb),
        .char_stb  (char_stb),
        .char_code (char_code),
        .char_err  (char_err)
    );

    // Receive buffer: load on a decoded character, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= 8'h00;
            rx_err  <= 1'b0;
        end else if (char_stb) begin
            rx_data <= char_code;
            rx_err  <= char_err;
        end
    end

    // Done and overrun flags: a new character wins over a read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_done <= 1'b0;
            rx_ovr  <= 1'b0;
        end else begin
            if (char_stb)   rx_done <= 1'b1;
            else if (rx_rd) rx_done <= 1'b0;

            if (char_stb && rx_done && !rx_rd) rx_ovr <= 1'b1;
            else if (rx_rd)                    rx_ovr <= 1'b0;
        end
    end

endmodule

// File: rtl/mrx_chk.sv
// Cycle-level checks on the receive buffer and its flags, bound to the top.
module mrx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_rd,
    input logic       char_stb,
    input logic [7:0] rx_data,
    input logic       rx_done,
    input logic       rx_err,
    input logic       rx_ovr
);

    AST_DONE_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        char_stb |=> rx_done); // R9

    AST_READ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !char_stb) |=> (!rx_done && !rx_ovr)); // R9

    AST_OVERRUN_ON_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && rx_done && !rx_rd) |=> rx_ovr); // R10

    AST_OVR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |-> rx_done); // R10

    AST_ERR_CODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> (rx_data == 8'h3F)); // R7

    AST_BUFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !char_stb |=> ($stable(rx_data) && $stable(rx_err))); // R11

endmodule

bind morse_rx_decoder mrx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_rd    (rx_rd),
    .char_stb (char_stb),
    .rx_data  (rx_data),
    .rx_done  (rx_done),
    .rx_err   (rx_err),
    .rx_ovr   (rx_ovr)
);

// File: tb/sim_morse_rx_decoder.sv
// Scoreboard bench: driver tasks key patterns and queue the expected
// character; a monitor pops and compares on each receive-done.
module sim_morse_rx_decoder;

    localparam int DIV  = 16;
    localparam int UT   = 4;
    localparam int UNIT = DIV * UT;

    logic       clk    = 1'b0;
    logic       rst_n  = 1'b0;
    logic       key_in = 1'b0;
    logic       rx_rd  = 1'b0;
    logic [7:0] rx_data;
    logic       rx_done;
    logic       rx_err;
    logic       rx_ovr;

    always #4 clk = ~clk;

    morse_rx_decoder #(.CLK_DIV(DIV), .UNIT_TICKS(UT)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_in  (key_in),
        .rx_rd   (rx_rd),
        .rx_data (rx_data),
        .rx_done (rx_done),
        .rx_err  (rx_err),
        .rx_ovr  (rx_ovr)
    );

    typedef struct {
        logic [7:0] code;
        logic       err;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;
    int   n_checks   = 0;
    int   n_fails    = 0;
    int   n_seen     = 0;
    bit   auto_read  = 1'b1;
    bit   force_read = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse(input int clks);
        @(negedge clk) key_in = 1'b1;
        repeat (clks) @(negedge clk);
        key_in = 1'b0;
    endtask

    task automatic space(input int clks);
        repeat (clks) @(negedge clk);
    endtask

    // Key a pattern of '.' and '-' at nominal speed and queue the expected result.
    task automatic send(input string pat, input logic [7:0] code,
                        input logic err, input string req);
        exp_t e;
        e.code = code; e.err = err; e.req = req;
        exp_q.push_back(e);
        for (int i = 0; i < pat.len(); i++) begin
            pulse((pat[i] == "-") ? 3 * UNIT : UNIT);
            if (i < pat.len() - 1) space(UNIT);
        end
        space(4 * UNIT);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    // Monitor: compare each received character against the queue head and read it.
    initial begin
        forever begin
            @(negedge clk);
            rx_rd = 1'b0;
            if (force_read) begin
                force_read = 1'b0;
                rx_rd = 1'b1;
            end else if (auto_read && rx_done) begin
                n_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected character", int'(rx_data), 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    check(rx_data == mon_e.code, mon_e.req, "code", int'(rx_data), int'(mon_e.code));
                    check(rx_err == mon_e.err, mon_e.req, "error flag", int'(rx_err), int'(mon_e.err));
                    check(rx_ovr == 1'b0, "R10", "overrun in paced stream", int'(rx_ovr), 0);
                end
                rx_rd = 1'b1;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int seen0;
        repeat (5) @(negedge clk);
        check(rx_done == 1'b0, "R1", "reset done", int'(rx_done), 0);
        check(rx_err == 1'b0, "R1", "reset err", int'(rx_err), 0);
        check(rx_ovr == 1'b0, "R1", "reset ovr", int'(rx_ovr), 0);
        check(rx_data == 8'h00, "R1", "reset data", int'(rx_data), 0);
        rst_n = 1'b1;
        space(2 * UNIT);

        // Letters and digits at nominal timing.
        send("...",   8'h53, 1'b0, "R6");
        send("---",   8'h4F, 1'b0, "R6");
        send("--.-",  8'h51, 1'b0, "R6");
        send("--...", 8'h37, 1'b0, "R6");
        send("-----", 8'h30, 1'b0, "R6");
        send(".....", 8'h35, 1'b0, "R6");
        send(".",     8'h45, 1'b0, "R2");
        send("-",     8'h54, 1'b0, "R3");

        // Near-threshold pulses: just under two units is a dot, just over is a dash.
        exp_q.push_back('{code: 8'h45, err: 1'b0, req: "R2"});
        pulse(7 * DIV - 8);  space(4 * UNIT);
        exp_q.push_back('{code: 8'h54, err: 1'b0, req: "R3"});
        pulse(9 * DIV + 8);  space(4 * UNIT);
        // Just over half a unit still counts as a dot.
        exp_q.push_back('{code: 8'h49, err: 1'b0, req: "R2"});
        pulse(40); space(UNIT); pulse(40); space(4 * UNIT);

        // Glitch in idle time produces nothing.
        seen0 = n_seen;
        pulse(DIV); space(4 * UNIT);
        check(n_seen == seen0, "R4", "idle glitch chars", n_seen - seen0, 0);
        check(rx_done == 1'b0, "R4", "idle glitch done", int'(rx_done), 0);

        // Glitch inside a character adds no element: dot, glitch, dot gives I.
        exp_q.push_back('{code: 8'h49, err: 1'b0, req: "R4"});
        pulse(UNIT); space(UNIT / 2); pulse(10); space(UNIT / 2);
        pulse(UNIT); space(4 * UNIT);

        // Gap of 1.5 units keeps one character (A); 2.5 units splits it (E, T).
        exp_q.push_back('{code: 8'h41, err: 1'b0, req: "R5"});
        pulse(UNIT); space(3 * UNIT / 2); pulse(3 * UNIT); space(4 * UNIT);
        exp_q.push_back('{code: 8'h45, err: 1'b0, req: "R5"});
        exp_q.push_back('{code: 8'h54, err: 1'b0, req: "R5"});
        pulse(UNIT); space(5 * UNIT / 2); pulse(3 * UNIT); space(4 * UNIT);

        // Error frames, then a good character clears the error flag.
        send("......", 8'h3F, 1'b1, "R7");
        send("..--",   8'h3F, 1'b1, "R8");
        send(".-.-.",  8'h3F, 1'b1, "R8");
        send("-..",    8'h44, 1'b0, "R8");

        // Overrun: two characters with no read in between.
        auto_read = 1'b0;
        pulse(UNIT);     space(4 * UNIT);
        pulse(3 * UNIT); space(4 * UNIT);
        check(rx_done == 1'b1, "R10", "done after overrun", int'(rx_done), 1);
        check(rx_ovr == 1'b1, "R10", "overrun flag", int'(rx_ovr), 1);
        check(rx_data == 8'h54, "R10", "newest char kept", int'(rx_data), 8'h54);
        force_read = 1'b1;
        space(3);
        check(rx_done == 1'b0, "R9", "done cleared by read", int'(rx_done), 0);
        check(rx_ovr == 1'b0, "R10", "overrun cleared by read", int'(rx_ovr), 0);
        check(rx_data == 8'h54, "R11", "data held after read", int'(rx_data), 8'h54);
        space(2 * UNIT);
        check(rx_data == 8'h54, "R11", "data held while idle", int'(rx_data), 8'h54);
        auto_read = 1'b1;

        space(4 * UNIT);
        check(exp_q.size() == 0, "R9", "characters still pending", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule